// File: doc/BRIEF.md
# Add-compare-select slice with banked path-metric memories

This block is one quarter of the survivor-selection engine of a 64-state soft-decision Viterbi decoder. It looks after 16 trellis states. One state is handled for each accepted input. The slice adds an upper branch metric to its own stored metric for that state, and it adds a lower branch metric to a metric that a neighbouring slice supplies over fixed wiring. It keeps the smaller sum under wrap-around comparison. It writes that sum back as the state's new path metric and emits one decision bit for the traceback logic.

Path metrics are kept in four small 8-word by 9-bit register-file banks. There are two copies (old and new) of the two halves of the slice's states. In every step the reads come from the old copy and the writes go to the new copy, and the roles swap after sixteen accepted inputs. The metric read from the old copy also leaves the slice through a copy/half multiplexer so that the neighbouring slices can use it. A pipeline register separates the two adders from the compare-select stage. Metrics are never renormalized; the 9-bit wrap-around comparison handles overflow.

Top module: `acs_slice`

## Requirements
- R1: After reset, decisionValid is low and the old copy holds metric 0 for local state 0 and 128 for local states 1 to 15, so the first step reads these values.
- R2: For the state being handled, the upper sum is the stored old metric plus bmUpper, and the lower sum is nbrMetric plus bmLower, both taken modulo 512. nbrMetric is sampled in the cycle that follows the cycle in which inValid is high.
- R3: decisionBit is 1 when the lower sum wins, which is when (lowerSum - upperSum) mod 512 is 256 or more. It is 0 otherwise, and a tie gives 0.
- R4: survivorMetric is the winning sum. It is stored as the new metric of that state and is read back in the next step.
- R5: The outputs for an input accepted at a rising edge are presented by the second rising edge after it, with decisionValid high for exactly one cycle per accepted input.
- R6: Accepted inputs are assigned local states 0, 1, ..., 15 in order, and decisionIdx reports that index. After state 15 the index wraps to 0 and the old and new copies swap.
- R7: One cycle after an input is accepted, shareMetric shows that state's metric from the old copy, which the current step's writes have not altered. No more than two banks are enabled in any cycle, and the bank being read is never the bank being written.
- R8: A cycle with inValid low advances no state, produces no decision, and changes no stored metric or shareMetric, whatever values the branch-metric and neighbour inputs carry.
- R9: Sums that pass 511 wrap around without renormalization, and R3 still picks the truly smaller metric whenever the two sums differ by less than 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Accept one state's branch metrics this cycle |
| bmUpper | input | 4 | Branch metric added to the slice's own old metric |
| bmLower | input | 4 | Branch metric added to the neighbour metric |
| nbrMetric | input | 9 | Lower predecessor metric from a neighbouring slice, one cycle after inValid |
| shareMetric | output | 9 | Old metric read this step, sent to neighbouring slices |
| decisionValid | output | 1 | Decision and survivor outputs are valid |
| decisionBit | output | 1 | 1 when the lower predecessor survived |
| decisionIdx | output | 4 | Local state index of the decision |
| survivorMetric | output | 9 | New path metric of that state |

## Verification
At a step boundary the slice can read the old copy for state 0 of the new step in the same cycle that it is still writing the pipelined survivors of states 14 and 15 of the previous step, and those writes land in the copy that has just become old. The bench provokes this by presenting inputs back to back across many step boundaries, and also by inserting random gaps that move the boundary to different pipeline phases. It judges the result by comparing every shareMetric value with a model of the old copy, and every decision and survivor with the same model. A read that returned a half-written or wrong-copy metric would therefore show up one step later as a mismatch.

// File: rtl/acs_pkg.sv
package acs_pkg;
  parameter int PM_W         = 9;
  parameter int BM_W         = 4;
  parameter int SLICE_STATES = 16;
  parameter int BANK_WORDS   = 8;
  parameter int INIT_FAR     = 128;

  localparam int IDX_W      = $clog2(SLICE_STATES);
  localparam int ADDR_W     = $clog2(BANK_WORDS);
  localparam int NUM_HALVES = SLICE_STATES / BANK_WORDS;
  localparam int NUM_BANKS  = 2 * NUM_HALVES;
  localparam int BANK_W     = $clog2(NUM_BANKS);

  // strobes from control to datapath
  typedef struct packed {
    logic             rdEn;
    logic             rdCopy;
    logic [IDX_W-1:0] idx;
  } acsStrobe_t;
endpackage

// File: rtl/acs_pm_bank.sv
module acs_pm_bank #(
  parameter int PM_W         = 9,
  parameter int WORDS        = 8,
  parameter int ADDR_W       = 3,
  parameter bit HOLDS_ORIGIN = 1'b0,
  parameter int INIT_FAR     = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PM_W-1:0]   rdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PM_W-1:0]   wrData
);
  logic [PM_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) begin
        mem[i] <= (HOLDS_ORIGIN && i == 0) ? '0 : PM_W'(INIT_FAR);
      end
    end else if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/acs_slice_ctrl.sv
module acs_slice_ctrl
  import acs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output acsStrobe_t strobe
);
  logic [IDX_W-1:0] stateIdx;
  logic             oldCopy;
  logic             lastState;

  assign lastState = (stateIdx == IDX_W'(SLICE_STATES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateIdx <= '0;
      oldCopy  <= 1'b0;
    end else if (inValid) begin
      if (lastState) begin
        stateIdx <= '0;
        oldCopy  <= ~oldCopy;
      end else begin
        stateIdx <= stateIdx + IDX_W'(1);
      end
    end
  end

  always_comb begin
    strobe.rdEn   = inValid;
    strobe.rdCopy = oldCopy;
    strobe.idx    = stateIdx;
  end
endmodule

// File: rtl/acs_slice_dp.sv
module acs_slice_dp
  import acs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  acsStrobe_t           strobe,
  input  logic [BM_W-1:0]      bmUpper,
  input  logic [BM_W-1:0]      bmLower,
  input  logic [PM_W-1:0]      nbrMetric,
  output logic [PM_W-1:0]      shareMetric,
  output logic                 decisionValid,
  output logic                 decisionBit,
  output logic [IDX_W-1:0]     decisionIdx,
  output logic [PM_W-1:0]      survivorMetric,
  output logic [NUM_BANKS-1:0] bankRdEn,
  output logic [NUM_BANKS-1:0] bankWrEn
);
  // add stage registers
  logic             s1Valid;
  logic             s1Copy;
  logic [IDX_W-1:0] s1Idx;
  logic [BM_W-1:0]  s1BmU;
  logic [BM_W-1:0]  s1BmL;
  // compare-select stage registers
  logic             s2Valid;
  logic             s2Copy;
  logic [IDX_W-1:0] s2Idx;
  logic [PM_W-1:0]  s2SumU;
  logic [PM_W-1:0]  s2SumL;

  logic [PM_W-1:0]   bankData [NUM_BANKS];
  logic [BANK_W-1:0] rdBank;
  logic [BANK_W-1:0] wrBank;
  logic [BANK_W-1:0] shareSel;
  logic [PM_W-1:0]   sumUpper;
  logic [PM_W-1:0]   sumLower;
  logic [PM_W-1:0]   sumGap;
  logic              lowerWins;
  logic [PM_W-1:0]   winner;

  assign rdBank   = BANK_W'(strobe.rdCopy) * BANK_W'(NUM_HALVES)
                  + BANK_W'(strobe.idx >> ADDR_W);
  assign wrBank   = BANK_W'(s2Copy) * BANK_W'(NUM_HALVES)
                  + BANK_W'(s2Idx >> ADDR_W);
  assign shareSel = BANK_W'(s1Copy) * BANK_W'(NUM_HALVES)
                  + BANK_W'(s1Idx >> ADDR_W);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    assign bankRdEn[g] = strobe.rdEn && (rdBank == BANK_W'(g));
    assign bankWrEn[g] = s2Valid && (wrBank == BANK_W'(g));

    acs_pm_bank #(
      .PM_W        (PM_W),
      .WORDS       (BANK_WORDS),
      .ADDR_W      (ADDR_W),
      .HOLDS_ORIGIN(g == 0),
      .INIT_FAR    (INIT_FAR)
    ) uBank (
      .clk   (clk),
      .rstN  (rstN),
      .rdEn  (bankRdEn[g]),
      .rdAddr(strobe.idx[ADDR_W-1:0]),
      .rdData(bankData[g]),
      .wrEn  (bankWrEn[g]),
      .wrAddr(s2Idx[ADDR_W-1:0]),
      .wrData(winner)
    );
  end

  // the output multiplexer toward neighbouring slices
  assign shareMetric = bankData[shareSel];

  // add stage
  assign sumUpper = shareMetric + PM_W'(s1BmU);
  assign sumLower = nbrMetric + PM_W'(s1BmL);

  // compare-select stage, wrap-around compare
  assign sumGap    = s2SumL - s2SumU;
  assign lowerWins = sumGap[PM_W-1];
  assign winner    = lowerWins ? s2SumL : s2SumU;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Copy  <= 1'b0;
      s1Idx   <= '0;
      s1BmU   <= '0;
      s1BmL   <= '0;
    end else begin
      s1Valid <= strobe.rdEn;
      if (strobe.rdEn) begin
        s1Copy <= strobe.rdCopy;
        s1Idx  <= strobe.idx;
        s1BmU  <= bmUpper;
        s1BmL  <= bmLower;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Copy  <= 1'b0;
      s2Idx   <= '0;
      s2SumU  <= '0;
      s2SumL  <= '0;
    end else begin
      s2Valid <= s1Valid;
      if (s1Valid) begin
        s2Copy <= ~s1Copy;
        s2Idx  <= s1Idx;
        s2SumU <= sumUpper;
        s2SumL <= sumLower;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decisionValid  <= 1'b0;
      decisionBit    <= 1'b0;
      decisionIdx    <= '0;
      survivorMetric <= '0;
    end else begin
      decisionValid <= s2Valid;
      if (s2Valid) begin
        decisionBit    <= lowerWins;
        decisionIdx    <= s2Idx;
        survivorMetric <= winner;
      end
    end
  end
endmodule

// File: rtl/acs_slice.sv
module acs_slice
  import acs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [BM_W-1:0]       bmUpper,
  input  logic [BM_W-1:0]       bmLower,
  input  logic [PM_W-1:0]       nbrMetric,
  output logic [PM_W-1:0]       shareMetric,
  output logic                  decisionValid,
  output logic                  decisionBit,
  output logic [IDX_W-1:0]      decisionIdx,
  output logic [PM_W-1:0]       survivorMetric
);
  acsStrobe_t           strobe;
  logic [NUM_BANKS-1:0] bankRdEn;
  logic [NUM_BANKS-1:0] bankWrEn;

  acs_slice_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobe (strobe)
  );

  acs_slice_dp uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .bmUpper       (bmUpper),
    .bmLower       (bmLower),
    .nbrMetric     (nbrMetric),
    .shareMetric   (shareMetric),
    .decisionValid (decisionValid),
    .decisionBit   (decisionBit),
    .decisionIdx   (decisionIdx),
    .survivorMetric(survivorMetric),
    .bankRdEn      (bankRdEn),
    .bankWrEn      (bankWrEn)
  );
endmodule

// File: rtl/acs_slice_chk.sv
module acs_slice_chk
  import acs_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 decisionValid,
  input logic [IDX_W-1:0]     decisionIdx,
  input logic [PM_W-1:0]      shareMetric,
  input logic [NUM_BANKS-1:0] bankRdEn,
  input logic [NUM_BANKS-1:0] bankWrEn
);
  logic [1:0]       sinceRst;
  logic [IDX_W-1:0] lastIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      lastIdx  <= IDX_W'(SLICE_STATES - 1);
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (decisionValid) lastIdx <= decisionIdx;
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (decisionValid == $past(inValid, 3)));

  p_idx_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> (decisionIdx == IDX_W'(lastIdx + IDX_W'(1))));

  p_bank_budget_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bankRdEn | bankWrEn) <= 2);

  p_rd_wr_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bankRdEn & bankWrEn) == '0);

  p_share_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && !$past(inValid)) |-> $stable(shareMetric));
endmodule

bind acs_slice acs_slice_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .decisionValid(decisionValid),
  .decisionIdx  (decisionIdx),
  .shareMetric  (shareMetric),
  .bankRdEn     (bankRdEn),
  .bankWrEn     (bankWrEn)
);

// File: tb/tb_acs_slice.sv
`timescale 1ns/1ps
module tb_acs_slice;
  localparam int NCYC = 1400;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [3:0] bmUpper, bmLower;
  logic [8:0] nbrMetric, shareMetric, survivorMetric;
  logic       decisionValid, decisionBit;
  logic [3:0] decisionIdx;

  always #2 clk = ~clk;

  acs_slice dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .bmUpper(bmUpper),
    .bmLower(bmLower), .nbrMetric(nbrMetric), .shareMetric(shareMetric),
    .decisionValid(decisionValid), .decisionBit(decisionBit),
    .decisionIdx(decisionIdx), .survivorMetric(survivorMetric)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit         expValid [NCYC];
  logic [3:0] expIdx   [NCYC];
  logic       expBit   [NCYC];
  logic [8:0] expSurv  [NCYC];
  logic [8:0] expShare [NCYC];
  logic [8:0] nbrVal   [NCYC];
  logic [8:0] pmOld [16];
  logic [8:0] pmNew [16];
  int mk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic lowerWinsModel(logic [8:0] su, logic [8:0] sl);
    logic [8:0] d;
    d = sl - su;
    return d >= 9'd256;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) pmOld[i] = (i == 0) ? 9'd0 : 9'd128;
    mk = 0;
    rstN = 1'b0; inValid = 1'b0; bmUpper = '0; bmLower = '0; nbrMetric = '0;
    repeat (3) @(negedge clk);
    check("R1", decisionValid, 0, "decisionValid in reset");
    rstN = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      logic       v;
      logic [3:0] bu, bl;
      logic [8:0] nb, su, sl;
      @(negedge clk);
      if (cyc >= 1 && expValid[cyc-1])
        check((cyc - 1 < 16) ? "R1" : "R7", shareMetric, expShare[cyc-1], "shareMetric");
      if (cyc >= 3) begin
        check(expValid[cyc-3] ? "R5" : "R8", decisionValid, expValid[cyc-3], "decisionValid");
        if (expValid[cyc-3] && decisionValid) begin
          check("R6", decisionIdx, expIdx[cyc-3], "decisionIdx");
          check("R3", decisionBit, expBit[cyc-3], "decisionBit");
          check((cyc - 3 >= 16 && cyc - 3 < 32) ? "R9" : "R2/R4",
                survivorMetric, expSurv[cyc-3], "survivorMetric");
        end
      end
      // neighbour metric belongs to the input of the previous cycle
      if (cyc >= 1 && expValid[cyc-1]) nbrMetric = nbrVal[cyc-1];
      else nbrMetric = 9'($urandom);
      // choose this cycle's input
      if (cyc >= NCYC - 4) begin
        v = 1'b0; bu = 4'($urandom); bl = 4'($urandom); nb = '0;
      end else if (cyc < 16) begin
        v = 1'b1; bu = '0; bl = '0; nb = '0;          // tie for state 0
      end else if (cyc < 32) begin
        v = 1'b1; bu = 4'($urandom); bl = 4'd15; nb = 9'd505;  // wrap
      end else begin
        v  = ($urandom % 4) != 0;
        bu = 4'($urandom); bl = 4'($urandom);
        nb = pmOld[mk ^ 5] + 9'($urandom % 40);
      end
      if (v) begin
        su = pmOld[mk] + 9'(bu);
        sl = nb + 9'(bl);
        expValid[cyc] = 1'b1;
        expShare[cyc] = pmOld[mk];
        expIdx[cyc]   = 4'(mk);
        expBit[cyc]   = lowerWinsModel(su, sl);
        expSurv[cyc]  = expBit[cyc] ? sl : su;
        nbrVal[cyc]   = nb;
        pmNew[mk]     = expSurv[cyc];
        mk++;
        if (mk == 16) begin
          for (int i = 0; i < 16; i++) pmOld[i] = pmNew[i];
          mk = 0;
        end
      end
      inValid = v; bmUpper = bu; bmLower = bl;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule